// File: doc/BRIEF.md
# Machine State Register Write Controller

This block owns a 64-bit machine state register and applies move-to-register write requests to it. A requested value is not stored as given. It first passes through a chain of filters:

- The implemented-bits mask is applied.
- The hypervisor bit is locked unless the write is allowed to change it.
- The machine-check-enable bit is locked while the core runs as a guest.
- The interrupt-enable and both relocate bits are forced on whenever problem state is entered.

The filtered value is loaded on the clock edge that follows the write strobe. In the same edge the block compares the new value with the old one and raises one-cycle side-effect pulses:

- a translation-context flush when address translation changes;
- a shadow-register swap request when the temporary-register bit toggles.

It also reloads the exception vector prefix when the prefix-select bit changes.

A small two-state machine manages the halt request. In state `ST_RUN` the core executes. The transition `RUN_TO_HALTED` is taken when an applied write leaves the power-save bit set, no interrupt is pending, and power save is permitted. In state `ST_HALTED` the halt output is high. The transition `HALTED_TO_RUN` is taken on the first clock edge that sees an interrupt pending. Synchronous reset returns the machine to `ST_RUN`.

Configuration is by parameter:

| Parameter | Default | Meaning |
|---|---|---|
| `IMPL_MASK` | bits 0..60 implemented | implemented-bits mask |
| `SERVER_CLASS` | 1 | selects the server-class rules |
| `EMBEDDED_MMU` | 0 | enables the embedded-MMU rule |
| `TGPR_EN` | 1 | enables the temporary-register feature |
| `RESET_MSR` | hypervisor bit set | reset value of the register |

The reset value has the hypervisor bit set, because a cleared hypervisor bit can never be set again.

Top module: `msr_write_ctrl`

## Requirements

Bit positions: DR=4, IR=5, EP=6, ME=12, PR=14, EE=15, TGPR=17, POW=18, GS=28, HV=60.

- R1: Bits that are clear in IMPL_MASK are stored as 0; with the default mask, request bits 61..63 never appear in the register.
- R2: The HV bit (60) keeps its old value unless alter_hv_i is 1 and the current HV bit is 1.
- R3: With SERVER_CLASS=1 and current HV=0, the ME bit (12) keeps its old value whatever the request holds.
- R4: A change of IR (bit 5) or DR (bit 4) raises flush_o for exactly one cycle. The comparison uses the value before problem-state forcing.
- R5: A change of GS (bit 28) raises flush_o only when EMBEDDED_MMU=1; with the default of 0 it raises nothing.
- R6: With TGPR_EN=1, a toggle of TGPR (bit 17) raises gpr_swap_o for one cycle.
- R7: When EP (bit 6) changes, vec_prefix_o becomes 0xFFF00000 if the new EP is 1 and 0 if it is 0; otherwise the prefix is held.
- R8: With SERVER_CLASS=1, a filtered value with PR (bit 14) set is stored with EE (15), IR (5) and DR (4) also set.
- R9: After a write whose stored value has POW (bit 18) set, with irq_pending_i=0 and pwrsave_ok_i=1 in the strobe cycle, halt_o rises on the next edge. It stays high until the first edge that sees irq_pending_i=1, then clears.
- R10: Synchronous reset loads RESET_MSR, clears vec_prefix_o, flush_o and gpr_swap_o, and returns halt to 0.
- R11: The register and all event outputs change on the edge after the strobe. In cycles without a strobe the register holds and the pulses are 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write strobe for one request |
| wr_data_i | input | 64 | Requested register value |
| alter_hv_i | input | 1 | Write is qualified to change the hypervisor bit |
| irq_pending_i | input | 1 | An interrupt is pending |
| pwrsave_ok_i | input | 1 | Power save is permitted |
| msr_o | output | 64 | Current register value |
| vec_prefix_o | output | 64 | Exception vector prefix |
| flush_o | output | 1 | One-cycle translation flush pulse |
| gpr_swap_o | output | 1 | One-cycle shadow register swap request |
| halt_o | output | 1 | Halt request |

## Verification

Two functions can act in the same write: problem-state forcing and the relocate-change flush. One request sets PR while clearing IR and DR that were previously set. Forcing restores IR and DR in the stored value, so the bench expects the stored value to have them set. Because the flush decision uses the pre-forcing value, the bench also expects flush_o high. A second overlap is provoked with one write that toggles TGPR, clears EP and changes GS. It is judged by a high swap pulse, a zero prefix and a low flush pulse, all in the same cycle.

// File: rtl/msr_wr_pkg.sv
package msr_wr_pkg;

    // Bit positions inside the machine state register
    localparam int unsigned BIT_DR   = 4;
    localparam int unsigned BIT_IR   = 5;
    localparam int unsigned BIT_EP   = 6;
    localparam int unsigned BIT_ME   = 12;
    localparam int unsigned BIT_PR   = 14;
    localparam int unsigned BIT_EE   = 15;
    localparam int unsigned BIT_TGPR = 17;
    localparam int unsigned BIT_POW  = 18;
    localparam int unsigned BIT_GS   = 28;
    localparam int unsigned BIT_HV   = 60;

    localparam logic [31:0] PREFIX_HIGH = 32'hFFF0_0000;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_HALTED = 1'b1
    } halt_state_e;

    typedef struct packed {
        logic flush;
        logic swap;
        logic ep_chg;
    } msr_events_t;

endpackage

// File: rtl/msr_filter.sv
module msr_filter
    import msr_wr_pkg::*;
#(
    parameter int unsigned XLEN         = 64,
    parameter logic [XLEN-1:0] IMPL_MASK = '1,
    parameter bit          SERVER_CLASS = 1'b1
) (
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] req_i,
    input  logic            alter_hv_i,
    output logic [XLEN-1:0] pre_force_o,
    output logic [XLEN-1:0] final_o
);

    logic [XLEN-1:0] masked;
    logic [XLEN-1:0] hv_fixed;
    logic [XLEN-1:0] me_fixed;
    logic            hv_may_change;

    assign hv_may_change = alter_hv_i & old_i[BIT_HV];

    always_comb begin
        masked = req_i & IMPL_MASK;

        hv_fixed = masked;
        if (!hv_may_change) begin
            hv_fixed[BIT_HV] = old_i[BIT_HV];
        end

        me_fixed = hv_fixed;
        if (SERVER_CLASS && !old_i[BIT_HV]) begin
            me_fixed[BIT_ME] = old_i[BIT_ME];
        end
    end

    assign pre_force_o = me_fixed;

    generate
        if (SERVER_CLASS) begin : g_force
            always_comb begin
                final_o = me_fixed;
                if (me_fixed[BIT_PR]) begin
                    final_o[BIT_EE] = 1'b1;
                    final_o[BIT_IR] = 1'b1;
                    final_o[BIT_DR] = 1'b1;
                end
            end
        end else begin : g_noforce
            assign final_o = me_fixed;
        end
    endgenerate

endmodule

// File: rtl/msr_event_detect.sv
module msr_event_detect
    import msr_wr_pkg::*;
#(
    parameter int unsigned XLEN         = 64,
    parameter bit          EMBEDDED_MMU = 1'b0,
    parameter bit          TGPR_EN      = 1'b1
) (
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] pre_force_i,
    input  logic [XLEN-1:0] final_i,
    output msr_events_t     ev_o
);

    logic reloc_chg;
    logic gs_chg;

    assign reloc_chg = (old_i[BIT_IR] ^ pre_force_i[BIT_IR]) |
                       (old_i[BIT_DR] ^ pre_force_i[BIT_DR]);

    generate
        if (EMBEDDED_MMU) begin : g_gs
            assign gs_chg = old_i[BIT_GS] ^ final_i[BIT_GS];
        end else begin : g_nogs
            assign gs_chg = 1'b0;
        end
        if (TGPR_EN) begin : g_tgpr
            assign ev_o.swap = old_i[BIT_TGPR] ^ final_i[BIT_TGPR];
        end else begin : g_notgpr
            assign ev_o.swap = 1'b0;
        end
    endgenerate

    assign ev_o.flush  = reloc_chg | gs_chg;
    assign ev_o.ep_chg = old_i[BIT_EP] ^ final_i[BIT_EP];

endmodule

// File: rtl/msr_halt_fsm.sv
module msr_halt_fsm
    import msr_wr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic wr_en_i,
    input  logic new_pow_i,
    input  logic irq_pending_i,
    input  logic pwrsave_ok_i,
    output logic halt_o
);

    halt_state_e state_q, state_d;
    logic        enter_halt;

    assign enter_halt = wr_en_i & new_pow_i & ~irq_pending_i & pwrsave_ok_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (enter_halt)    state_d = ST_HALTED; // RUN_TO_HALTED
            ST_HALTED: if (irq_pending_i) state_d = ST_RUN;    // HALTED_TO_RUN
            default:                      state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_RUN;
        else       state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_HALTED: halt_o = 1'b1;
            default:   halt_o = 1'b0;
        endcase
    end

    // R9: a pending interrupt releases halt on the next edge
    p_halt_release_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (halt_o && irq_pending_i) |=> !halt_o);

    // R9: halt only rises after a qualifying write
    p_halt_entry_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(halt_o) |-> $past(wr_en_i && new_pow_i && !irq_pending_i && pwrsave_ok_i));

endmodule

// File: rtl/msr_write_ctrl.sv
module msr_write_ctrl
    import msr_wr_pkg::*;
#(
    parameter int unsigned     XLEN         = 64,
    parameter logic [XLEN-1:0] IMPL_MASK    = 64'h1FFF_FFFF_FFFF_FFFF,
    parameter logic [XLEN-1:0] RESET_MSR    = 64'h1000_0000_0000_0000,
    parameter bit              SERVER_CLASS = 1'b1,
    parameter bit              EMBEDDED_MMU = 1'b0,
    parameter bit              TGPR_EN      = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic            alter_hv_i,
    input  logic            irq_pending_i,
    input  logic            pwrsave_ok_i,
    output logic [XLEN-1:0] msr_o,
    output logic [XLEN-1:0] vec_prefix_o,
    output logic            flush_o,
    output logic            gpr_swap_o,
    output logic            halt_o
);

    localparam logic [XLEN-1:0] PREFIX_VAL = {{(XLEN-32){1'b0}}, PREFIX_HIGH};
    localparam logic [XLEN-1:0] FORCE_BITS = (XLEN'(1) << BIT_EE) |
                                             (XLEN'(1) << BIT_IR) |
                                             (XLEN'(1) << BIT_DR);

    logic [XLEN-1:0] msr_q;
    logic [XLEN-1:0] prefix_q;
    logic            flush_q;
    logic            swap_q;
    logic [XLEN-1:0] pre_force;
    logic [XLEN-1:0] new_val;
    msr_events_t     ev;

    msr_filter #(
        .XLEN         (XLEN),
        .IMPL_MASK    (IMPL_MASK),
        .SERVER_CLASS (SERVER_CLASS)
    ) u_filter (
        .old_i       (msr_q),
        .req_i       (wr_data_i),
        .alter_hv_i  (alter_hv_i),
        .pre_force_o (pre_force),
        .final_o     (new_val)
    );

    msr_event_detect #(
        .XLEN         (XLEN),
        .EMBEDDED_MMU (EMBEDDED_MMU),
        .TGPR_EN      (TGPR_EN)
    ) u_events (
        .old_i       (msr_q),
        .pre_force_i (pre_force),
        .final_i     (new_val),
        .ev_o        (ev)
    );

    msr_halt_fsm u_halt (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .wr_en_i       (wr_en_i),
        .new_pow_i     (new_val[BIT_POW]),
        .irq_pending_i (irq_pending_i),
        .pwrsave_ok_i  (pwrsave_ok_i),
        .halt_o        (halt_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            msr_q    <= RESET_MSR;
            prefix_q <= '0;
            flush_q  <= 1'b0;
            swap_q   <= 1'b0;
        end else begin
            flush_q <= wr_en_i & ev.flush;
            swap_q  <= wr_en_i & ev.swap;
            if (wr_en_i) begin
                msr_q <= new_val;
                if (ev.ep_chg) begin
                    prefix_q <= new_val[BIT_EP] ? PREFIX_VAL : '0;
                end
            end
        end
    end

    assign msr_o        = msr_q;
    assign vec_prefix_o = prefix_q;
    assign flush_o      = flush_q;
    assign gpr_swap_o   = swap_q;

    // R1: no unimplemented bit outside the forced set is ever stored
    p_mask_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (msr_q & ~(IMPL_MASK | FORCE_BITS)) == '0);

    // R2: hypervisor bit is locked on unqualified writes
    p_hv_lock_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !(alter_hv_i && msr_q[BIT_HV])) |=> $stable(msr_q[BIT_HV]));

    // R3: machine-check enable is frozen in guest state
    p_me_lock_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (SERVER_CLASS && wr_en_i && !msr_q[BIT_HV]) |=> $stable(msr_q[BIT_ME]));

    // R8: problem state implies the three forced enables
    p_pr_force_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (SERVER_CLASS && msr_q[BIT_PR]) |-> (msr_q[BIT_EE] && msr_q[BIT_IR] && msr_q[BIT_DR]));

    // R7: prefix always tracks the stored prefix-select bit
    p_prefix_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        prefix_q == (msr_q[BIT_EP] ? PREFIX_VAL : '0));

    // R11: pulses only follow a strobe
    p_flush_src_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        flush_o |-> $past(wr_en_i));

    p_swap_src_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        gpr_swap_o |-> $past(wr_en_i));

    // R11: register holds without a strobe
    p_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_en_i |=> $stable(msr_q));

endmodule

// File: tb/msr_write_ctrl_bench.sv
`timescale 1ns/1ps
module msr_write_ctrl_bench;

    typedef struct packed {
        logic [63:0] data;
        logic        alter;
        logic        pend;
        logic        permit;
        logic [63:0] exp_msr;
        logic        exp_flush;
        logic        exp_swap;
        logic [63:0] exp_prefix;
        logic        exp_halt;
        logic [7:0]  req;
    } vec_t;

    localparam logic [63:0] PFX = 64'h0000_0000_FFF0_0000;
    localparam logic [63:0] HVB = 64'h1000_0000_0000_0000;

    localparam vec_t [0:10] VECS = '{
        // R1: unimplemented top bits dropped, R4 IR/DR change flushes
        '{64'hE000_0000_0000_0030, 1'b0, 1'b0, 1'b0, HVB | 64'h30,   1'b1, 1'b0, 64'h0, 1'b0, 8'd1},
        // R7: EP set loads high prefix
        '{64'h1000_0000_0000_1070, 1'b0, 1'b0, 1'b0, HVB | 64'h1070, 1'b0, 1'b0, PFX,   1'b0, 8'd7},
        // R2: qualified write clears HV
        '{64'h0000_0000_0000_1070, 1'b1, 1'b0, 1'b0, 64'h1070,       1'b0, 1'b0, PFX,   1'b0, 8'd2},
        // R3: guest cannot clear ME
        '{64'h0000_0000_0000_0070, 1'b0, 1'b0, 1'b0, 64'h1070,       1'b0, 1'b0, PFX,   1'b0, 8'd3},
        // R2: guest cannot set HV even with alter
        '{64'h1000_0000_0000_1070, 1'b1, 1'b0, 1'b0, 64'h1070,       1'b0, 1'b0, PFX,   1'b0, 8'd2},
        // R5 GS no flush, R6 TGPR swap, R7 EP clear
        '{64'h0000_0000_1002_1030, 1'b0, 1'b0, 1'b0, 64'h1002_1030,  1'b0, 1'b1, 64'h0, 1'b0, 8'd6},
        // R8 forcing with R4 flush from pre-force value
        '{64'h0000_0000_0000_5000, 1'b0, 1'b0, 1'b0, 64'hD030,       1'b1, 1'b1, 64'h0, 1'b0, 8'd8},
        // R4: leaving problem state drops IR/DR
        '{64'h0000_0000_0000_1000, 1'b0, 1'b0, 1'b0, 64'h1000,       1'b1, 1'b0, 64'h0, 1'b0, 8'd4},
        // R9: pending interrupt blocks halt
        '{64'h0000_0000_0004_1000, 1'b0, 1'b1, 1'b1, 64'h41000,      1'b0, 1'b0, 64'h0, 1'b0, 8'd9},
        // R9: not permitted blocks halt
        '{64'h0000_0000_0004_1000, 1'b0, 1'b0, 1'b0, 64'h41000,      1'b0, 1'b0, 64'h0, 1'b0, 8'd9},
        // R9: halt entered
        '{64'h0000_0000_0004_1000, 1'b0, 1'b0, 1'b1, 64'h41000,      1'b0, 1'b0, 64'h0, 1'b1, 8'd9}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [63:0] wr_data;
    logic        alter_hv;
    logic        irq_pending;
    logic        pwrsave_ok;
    logic [63:0] msr;
    logic [63:0] vec_prefix;
    logic        flush;
    logic        gpr_swap;
    logic        halt;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    msr_write_ctrl u_msr_write_ctrl (
        .clk_i         (clk),
        .rst_i         (rst),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .alter_hv_i    (alter_hv),
        .irq_pending_i (irq_pending),
        .pwrsave_ok_i  (pwrsave_ok),
        .msr_o         (msr),
        .vec_prefix_o  (vec_prefix),
        .flush_o       (flush),
        .gpr_swap_o    (gpr_swap),
        .halt_o        (halt)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; alter_hv = 1'b0;
        irq_pending = 1'b0; pwrsave_ok = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk("R10", "msr", msr, HVB);
        chk("R10", "prefix", vec_prefix, 64'h0);
        chk("R10", "flush", {63'b0, flush}, 64'h0);
        chk("R10", "halt", {63'b0, halt}, 64'h0);

        for (int i = 0; i < 11; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            wr_en       = 1'b1;
            wr_data     = VECS[i].data;
            alter_hv    = VECS[i].alter;
            irq_pending = VECS[i].pend;
            pwrsave_ok  = VECS[i].permit;
            @(posedge clk);
            @(negedge clk);
            chk(tag, $sformatf("v%0d msr", i), msr, VECS[i].exp_msr);
            chk(tag, $sformatf("v%0d flush", i), {63'b0, flush}, {63'b0, VECS[i].exp_flush});
            chk(tag, $sformatf("v%0d swap", i), {63'b0, gpr_swap}, {63'b0, VECS[i].exp_swap});
            chk(tag, $sformatf("v%0d prefix", i), vec_prefix, VECS[i].exp_prefix);
            chk(tag, $sformatf("v%0d halt", i), {63'b0, halt}, {63'b0, VECS[i].exp_halt});
            wr_en = 1'b0; irq_pending = 1'b0; pwrsave_ok = 1'b0; alter_hv = 1'b0;
            wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
            @(posedge clk);
            @(negedge clk);
            // R11: idle cycle holds register, pulses drop
            chk("R11", $sformatf("v%0d idle msr", i), msr, VECS[i].exp_msr);
            chk("R11", $sformatf("v%0d idle flush", i), {63'b0, flush}, 64'h0);
            chk("R11", $sformatf("v%0d idle swap", i), {63'b0, gpr_swap}, 64'h0);
        end

        // R9: halt persists without interrupt
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "halt held", {63'b0, halt}, 64'h1);
        irq_pending = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "halt released", {63'b0, halt}, 64'h0);
        irq_pending = 1'b0;

        // R9: enter halt again, then R10 reset clears it
        wr_en = 1'b1; wr_data = 64'h0000_0000_0004_1040; pwrsave_ok = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; pwrsave_ok = 1'b0;
        chk("R9", "halt re-entered", {63'b0, halt}, 64'h1);
        chk("R7", "prefix re-set", vec_prefix, PFX);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10", "msr after reset", msr, HVB);
        chk("R10", "prefix after reset", vec_prefix, 64'h0);
        chk("R10", "halt after reset", {63'b0, halt}, 64'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule